// File: doc/BRIEF.md
# Hypervisor Trap Control Register

This block holds the hypervisor's 32-bit trap-enable word. It covers five kinds of guest activity: access to the coprocessor-access-control register, access to activity-monitor registers, access to trace registers, SIMD-only instruction execution, and floating-point/SIMD access. Software writes the word through a data bus qualified by a write strobe. A read port always presents the architecturally visible value. A separate set of outputs gives the effective state of each trap, for use by the exception logic elsewhere in the core.

Reserved positions are fixed. Some fields disappear when optional hardware is absent, and that absence is reported through feature-present inputs. The secure monitor can force the trace, SIMD and floating-point fields to one while the core runs in non-secure state. While a field is forced it reads as one, behaves as one, and keeps its stored value unchanged. Writes to it are dropped. The block does not decide whether an access may reach the register, and it raises no exceptions.

Top module: `hyp_trap_ctl`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) clears every stored trap bit. With no field forced and FP/SIMD present, rd_data then reads 0x000033FF.
- R2: Bits 29:21, 19:16 and 14 always read 0, whatever is written.
- R3: Bits 13:12 and 9:0 always read 1, whatever is written.
- R4: Bit 31 is read/write. trap_cpctl equals its read value.
- R5: With feat_amu at 0, bit 30 reads 0, writes to it are dropped, and trap_actmon is 0. With feat_amu at 1, bit 30 is read/write and drives trap_actmon.
- R6: With feat_fpsimd at 0, bits 15, 11 and 10 read 1 and writes to them are dropped.
- R7: With ns_state and mon_trace_dis both 1, bit 20 reads 1 and trap_trace is 1. Otherwise bit 20 is read/write and drives trap_trace.
- R8: With ns_state and mon_simd_dis both 1, bit 15 reads 1. This holds even when the field is built read-as-zero.
- R9: With ns_state at 1 and mon_cp10_en at 0, bits 11 and 10 read 1. Bit 10's read value drives trap_fpsimd.
- R10: Bit 11 has no effect on any trap output. When it is not forced, it reads back the value last written to it, even if that differs from bit 10.
- R11: A write to a field that is forced to one leaves the field's stored value unchanged. The old value reappears once the force is released.
- R12: trap_simd is 1 only when bit 15 reads 1 and bit 10 reads 0.
- R13: With parameter SIMD_RW at 0, bit 15 reads 0 unless R6 or R8 forces it to 1. Writes to it are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| feat_amu | input | 1 | Activity-monitor feature present |
| feat_fpsimd | input | 1 | FP/SIMD feature present |
| ns_state | input | 1 | Core is in non-secure state |
| mon_trace_dis | input | 1 | Secure-monitor trace-access disable |
| mon_simd_dis | input | 1 | Secure-monitor SIMD disable |
| mon_cp10_en | input | 1 | Secure-monitor FP/SIMD enable |
| rd_data | output | 32 | Visible register value |
| trap_cpctl | output | 1 | Effective coprocessor-control access trap |
| trap_actmon | output | 1 | Effective activity-monitor trap |
| trap_trace | output | 1 | Effective trace-register trap |
| trap_simd | output | 1 | Effective SIMD-only execution trap |
| trap_fpsimd | output | 1 | Effective FP/SIMD trap |

## Verification
The bench builds two copies of the block that share every input: one with SIMD_RW at 1 and one with SIMD_RW at 0. Both the read/write and the read-as-zero forms of the SIMD field are therefore checked against the same stimulus. The six control inputs span only 64 combinations, so the bench visits all of them, with five write patterns in each. Between writes the force inputs change, and that change exercises dropped writes and the reappearance of stored values.

// File: rtl/htc_pkg.sv
package htc_pkg;
  localparam int DW       = 32;
  localparam int B_CPCTL  = 31;
  localparam int B_ACTMON = 30;
  localparam int B_TRACE  = 20;
  localparam int B_SIMD   = 15;
  localparam int B_FP2    = 11;
  localparam int B_FP     = 10;

  localparam logic [DW-1:0] RES1_M = 32'h0000_33FF;
  localparam logic [DW-1:0] RES0_M = 32'h3FEF_4000;

  typedef struct packed {
    logic amu;
    logic fpsimd;
  } feat_t;

  typedef struct packed {
    logic ns;
    logic trc_dis;
    logic simd_dis;
    logic cp10_en;
  } mon_t;

  // Bits that physically hold state for this feature set.
  function automatic logic [DW-1:0] live_bits(feat_t f, logic simd_rw);
    logic [DW-1:0] m;
    m = '0;
    m[B_CPCTL]  = 1'b1;
    m[B_ACTMON] = f.amu;
    m[B_TRACE]  = 1'b1;
    m[B_SIMD]   = f.fpsimd & simd_rw;
    m[B_FP2]    = f.fpsimd;
    m[B_FP]     = f.fpsimd;
    return m;
  endfunction

  // Bits that read as one and ignore writes for these conditions.
  function automatic logic [DW-1:0] forced_bits(feat_t f, mon_t c);
    logic [DW-1:0] m;
    logic fp_off;
    fp_off    = ~f.fpsimd | (c.ns & ~c.cp10_en);
    m         = '0;
    m[B_TRACE]= c.ns & c.trc_dis;
    m[B_SIMD] = ~f.fpsimd | (c.ns & c.simd_dis);
    m[B_FP2]  = fp_off;
    m[B_FP]   = fp_off;
    return m;
  endfunction
endpackage

// File: rtl/htc_mask.sv
module htc_mask
  import htc_pkg::*;
#(
  parameter bit SIMD_RW = 1'b1
) (
  input  feat_t         feat,
  input  mon_t          mon,
  output logic [DW-1:0] live_m,
  output logic [DW-1:0] force_m
);
  always_comb begin
    live_m  = live_bits(feat, SIMD_RW);
    force_m = forced_bits(feat, mon);
  end
endmodule

// File: rtl/htc_store.sv
module htc_store
  import htc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] live_m,
  input  logic [DW-1:0] force_m,
  output logic [DW-1:0] q
);
  logic [DW-1:0] wr_take;
  assign wr_take = {DW{wr_en}} & live_m & ~force_m;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)          q[i] <= 1'b0;
      else if (wr_take[i]) q[i] <= wr_data[i];
    end
  end

  // R1: reset clears storage
  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> q == '0);
  // R11: a forced field keeps its stored value across a write
  a_r11_forced_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q ^ $past(q)) & $past(force_m)) == '0);
  // R5/R6/R13: unimplemented fields never take write data
  a_r13_dead_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q ^ $past(q)) & ~$past(live_m)) == '0);
endmodule

// File: rtl/hyp_trap_ctl.sv
module hyp_trap_ctl
  import htc_pkg::*;
#(
  parameter bit SIMD_RW = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [31:0]   wr_data,
  input  logic          feat_amu,
  input  logic          feat_fpsimd,
  input  logic          ns_state,
  input  logic          mon_trace_dis,
  input  logic          mon_simd_dis,
  input  logic          mon_cp10_en,
  output logic [31:0]   rd_data,
  output logic          trap_cpctl,
  output logic          trap_actmon,
  output logic          trap_trace,
  output logic          trap_simd,
  output logic          trap_fpsimd
);
  feat_t         feat;
  mon_t          mon;
  logic [DW-1:0] live_m, force_m, q;

  assign feat = '{amu: feat_amu, fpsimd: feat_fpsimd};
  assign mon  = '{ns: ns_state, trc_dis: mon_trace_dis,
                  simd_dis: mon_simd_dis, cp10_en: mon_cp10_en};

  htc_mask #(.SIMD_RW(SIMD_RW)) u_mask (
    .feat(feat), .mon(mon), .live_m(live_m), .force_m(force_m)
  );

  htc_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .live_m(live_m), .force_m(force_m), .q(q)
  );

  assign rd_data     = RES1_M | force_m | (q & live_m);
  assign trap_cpctl  = rd_data[B_CPCTL];
  assign trap_actmon = rd_data[B_ACTMON];
  assign trap_trace  = rd_data[B_TRACE];
  assign trap_fpsimd = rd_data[B_FP];
  assign trap_simd   = rd_data[B_SIMD] & ~rd_data[B_FP];

  a_r2_res0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & RES0_M) == '0);
  a_r3_res1_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & RES1_M) == RES1_M);
  a_r5_amu_absent: assert property (@(posedge clk) disable iff (!rst_n)
    !feat_amu |-> !trap_actmon);
  a_r7_trace_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_state && mon_trace_dis) |-> trap_trace);
  a_r8_simd_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_state && mon_simd_dis) |-> rd_data[B_SIMD]);
  a_r9_fp_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (ns_state && !mon_cp10_en) |-> (rd_data[B_FP2] && trap_fpsimd));
  a_r12_simd_yields: assert property (@(posedge clk) disable iff (!rst_n)
    trap_fpsimd |-> !trap_simd);
endmodule

// File: tb/hyp_trap_ctl_tb.sv
module hyp_trap_ctl_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, wr_en;
  logic [31:0] wr_data;
  logic        amu, fp, ns, trc, sd, c10;
  logic [31:0] rd1, rd0;
  logic        tc1, ta1, tt1, ts1, tf1;
  logic        tc0, ta0, tt0, ts0, tf0;
  int          total = 0;
  int          bad = 0;
  logic [31:0] st1, st0;

  hyp_trap_ctl #(.SIMD_RW(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .feat_amu(amu), .feat_fpsimd(fp), .ns_state(ns), .mon_trace_dis(trc),
    .mon_simd_dis(sd), .mon_cp10_en(c10), .rd_data(rd1),
    .trap_cpctl(tc1), .trap_actmon(ta1), .trap_trace(tt1),
    .trap_simd(ts1), .trap_fpsimd(tf1));

  hyp_trap_ctl #(.SIMD_RW(1'b0)) u_dut_raz (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .feat_amu(amu), .feat_fpsimd(fp), .ns_state(ns), .mon_trace_dis(trc),
    .mon_simd_dis(sd), .mon_cp10_en(c10), .rd_data(rd0),
    .trap_cpctl(tc0), .trap_actmon(ta0), .trap_trace(tt0),
    .trap_simd(ts0), .trap_fpsimd(tf0));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(input logic [31:0] st, input bit rw);
    logic [31:0] r;
    logic fpf;
    fpf   = !fp || (ns && !c10);
    r     = 32'h0000_33FF;
    r[31] = st[31];
    r[30] = amu & st[30];
    r[20] = st[20] | (ns & trc);
    r[15] = fp ? ((rw & st[15]) | (ns & sd)) : 1'b1;
    r[11] = fpf | st[11];
    r[10] = fpf | st[10];
    return r;
  endfunction

  function automatic logic [31:0] model_wr(input logic [31:0] st, input logic [31:0] d, input bit rw);
    logic [31:0] s;
    logic fpf;
    fpf = !fp || (ns && !c10);
    s   = st;
    s[31] = d[31];
    if (amu) s[30] = d[30];
    if (!(ns && trc)) s[20] = d[20];
    if (rw && fp && !(ns && sd)) s[15] = d[15];
    if (!fpf) begin s[11] = d[11]; s[10] = d[10]; end
    return s;
  endfunction

  task automatic check_all();
    logic [31:0] e1, e0;
    e1 = model_rd(st1, 1'b1);
    e0 = model_rd(st0, 1'b0);
    chk("R2", rd1 & 32'h3FEF_4000, 32'h0);
    chk("R3", rd1 & 32'h0000_33FF, 32'h0000_33FF);
    chk("R4", {31'h0, rd1[31]}, {31'h0, e1[31]});
    chk("R4", {31'h0, tc1}, {31'h0, e1[31]});
    chk("R5", {31'h0, ta1}, {31'h0, e1[30]});
    chk("R7", {31'h0, tt1}, {31'h0, e1[20]});
    chk(fp ? "R8" : "R6", {31'h0, rd1[15]}, {31'h0, e1[15]});
    chk(fp ? "R9" : "R6", {31'h0, tf1}, {31'h0, e1[10]});
    chk("R10", {31'h0, rd1[11]}, {31'h0, e1[11]});
    chk("R12", {31'h0, ts1}, {31'h0, e1[15] & ~e1[10]});
    chk("R11", rd1, e1);
    chk("R13", rd0, e0);
    chk("R13", {31'h0, ts0}, {31'h0, e0[15] & ~e0[10]});
  endtask

  task automatic do_write(input logic [31:0] d);
    @(negedge clk);
    wr_data = d;
    wr_en   = 1'b1;
    @(posedge clk);
    st1 = model_wr(st1, d, 1'b1);
    st0 = model_wr(st0, d, 1'b0);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check_all();
  endtask

  task automatic set_cfg(input logic [5:0] c);
    @(negedge clk);
    {amu, fp, ns, trc, sd, c10} = c;
    #1;
    check_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    st1 = '0;
    st0 = '0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    {amu, fp, ns, trc, sd, c10} = 6'b11_0001;
    st1 = '0; st0 = '0;
    do_reset();
    #1;
    // R1: reset state
    chk("R1", rd1, 32'h0000_33FF);
    chk("R1", rd0, 32'h0000_33FF);
    chk("R1", {27'h0, tc1, ta1, tt1, ts1, tf1}, 32'h0);

    // R10: bit 11 set, bit 10 clear: reads back, no trap
    do_write(32'h0000_0800);
    chk("R10", {30'h0, rd1[11], tf1}, 32'h2);

    // R11: write while cp10 forced is dropped, old value returns
    do_write(32'hFFFF_FFFF);
    set_cfg(6'b11_1000);
    do_write(32'h0000_0000);
    set_cfg(6'b11_1001);
    chk("R11", {30'h0, rd1[11:10]}, 32'h3);

    // Exhaustive sweep of control inputs with several write patterns
    for (int c = 0; c < 64; c++) begin
      set_cfg(c[5:0]);
      do_write(32'hFFFF_FFFF);
      do_write(32'h0000_0000);
      do_write(32'hAAAA_AAAA);
      do_write(32'h5555_5555);
      do_write(32'hC010_8400 ^ {26'h0, c[5:0]});
    end

    // R1: reset mid-run clears stored bits
    set_cfg(6'b11_0001);
    do_write(32'hFFFF_FFFF);
    do_reset();
    #1;
    chk("R1", rd1, 32'h0000_33FF);
    chk("R1", rd0, 32'h0000_33FF);
    finish_run();
  end
endmodule